// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block divides the oscillator clock into the machine cycles of a classic 8-bit microcontroller core. A cycle has six states of two clocks each, and each state has a first and a second phase. A tick counter holds the current slot. A decoder turns that slot into the pulses the rest of the core needs: two code-fetch slots per cycle, a program-counter advance, an opcode capture, an end-of-execution pulse and the active-low program-memory read strobe.

An external data transfer takes two machine cycles. The core raises `xfer_req` during the first of them, and the request is taken in the last slot of that cycle. The next cycle then becomes a data cycle. In a data cycle both program fetches and both program strobes are dropped. A data read or write strobe is driven instead, and it lasts twice as long as a program strobe. Fetch and execute timing is the same whether code comes from internal or external memory.

Top module: `mcyc_sequencer`

## Requirements
- R1: A machine cycle is 12 clocks. `state_num` steps 1 to 6 and holds each value for two clocks. `ph1` is high on the first clock of a state and `ph2` on the second. After S6 Phase 2 the cycle wraps to S1 Phase 1.
- R2: While `rst` is high at a clock edge, the next state is S1 Phase 1 in a normal cycle. While `rst` is high, `fetch_a`, `fetch_b`, `op_latch`, `pc_inc` and `exec_done` are low and `prog_rd_n`, `data_rd_n` and `data_wr_n` are high. The first clock after release is S1 Phase 1.
- R3: In a normal cycle, `fetch_a` pulses in S1 Phase 1, `op_latch` in S1 Phase 2 and `fetch_b` in S4 Phase 1. Each pulse lasts one clock.
- R4: In a normal cycle, `pc_inc` is high in S1 Phase 1. It is also high in S4 Phase 1 when `more_bytes` is high in that clock. It is low in every other clock.
- R5: In a normal cycle, `prog_rd_n` is low from S1 Phase 2 through S2 Phase 2 and from S4 Phase 2 through S5 Phase 2, three clocks each. It is high in every other clock.
- R6: `xfer_req` is sampled at the clock edge that ends S6 Phase 2 of a normal cycle. If it is high, the next cycle is a data cycle. A data cycle has no `fetch_a`, `fetch_b`, `op_latch` or `pc_inc`, and `prog_rd_n` stays high for all 12 clocks. The cycle after a data cycle is always normal.
- R7: In a data cycle the data strobe is low from S1 Phase 2 through S4 Phase 1, six clocks. If `xfer_wr` was 1 at the sampling edge, `data_wr_n` is the strobe; if it was 0, `data_rd_n` is. The other data strobe stays high. Both data strobes stay high in normal cycles.
- R8: `exec_done` is high in S6 Phase 2 of a normal cycle when `xfer_req` is low in that clock, and in S6 Phase 2 of every data cycle. It is low in every other clock.
- R9: A high `xfer_req` outside S6 Phase 2 of a normal cycle, including any clock of a data cycle, has no effect on the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| more_bytes | input | 1 | Current instruction needs the byte from the second fetch |
| xfer_req | input | 1 | Request for a two-cycle external data transfer |
| xfer_wr | input | 1 | Transfer direction: 1 write, 0 read |
| state_num | output | 3 | Current state, 1 to 6 |
| ph1 | output | 1 | First half of the state |
| ph2 | output | 1 | Second half of the state |
| fetch_a | output | 1 | First code-fetch slot pulse |
| fetch_b | output | 1 | Second code-fetch slot pulse |
| op_latch | output | 1 | Opcode capture pulse |
| pc_inc | output | 1 | Program-counter advance enable |
| exec_done | output | 1 | Instruction execution complete |
| prog_rd_n | output | 1 | Program-memory read strobe, active low |
| data_rd_n | output | 1 | Data-memory read strobe, active low |
| data_wr_n | output | 1 | Data-memory write strobe, active low |

## Verification
The assertions assume that every input is a known, synchronous level that changes only between clock edges. They assume the core asks for a transfer only by holding `xfer_req` at the end of S6 of a normal cycle. They also assume that reset is held at least once before the first check. The stimulus is applied on falling edges. It puts noise on `xfer_req` in every slot except the sampling slot, so the ignore rule is exercised alongside real requests. It sweeps the request, direction and extra-byte patterns across many cycles, and it applies one reset in the middle of a cycle.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
    localparam int NUM_STATES    = 6;
    localparam int CLK_PER_STATE = 2;
    localparam int CYC_TICKS     = NUM_STATES * CLK_PER_STATE;
    localparam int TICK_W        = $clog2(CYC_TICKS);
    localparam int STATE_W       = $clog2(NUM_STATES + 1);

    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        logic dcyc;   // current cycle is the data cycle of a transfer
        logic dwr;    // direction captured with the request
    } mode_t;
endpackage

// File: rtl/mcyc_tick_ctr.sv
module mcyc_tick_ctr
    import mcyc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output tick_t              tick,
    output logic [STATE_W-1:0] state_num,
    output logic               ph1,
    output logic               ph2,
    output logic               last
);
    localparam tick_t LAST_TICK = tick_t'(CYC_TICKS - 1);
    localparam tick_t CPS       = tick_t'(CLK_PER_STATE);

    typedef struct packed {
        tick_t tick;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (rst) begin
            c_d.tick = '0;
        end else if (c_q.tick == LAST_TICK) begin
            c_d.tick = '0;
        end else begin
            c_d.tick = c_q.tick + tick_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign tick      = c_q.tick;
    assign last      = (c_q.tick == LAST_TICK);
    assign state_num = STATE_W'(c_q.tick / CPS) + STATE_W'(1);
    assign ph1       = ((c_q.tick % CPS) == '0);
    assign ph2       = ((c_q.tick % CPS) == tick_t'(CLK_PER_STATE - 1));

    // R1: the tick advances by one every clock until the last slot
    a_r1_tick_step: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && c_q.tick != LAST_TICK) |-> c_q.tick == tick_t'($past(c_q.tick) + tick_t'(1)));

    // R1: the last slot is followed by the first
    a_r1_tick_wrap: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && c_q.tick == LAST_TICK) |-> c_q.tick == '0);

    // R2: reset puts the sequencer in the first slot
    a_r2_reset_slot: assert property (@(posedge clk)
        rst |=> c_q.tick == '0);
endmodule

// File: rtl/mcyc_mode_reg.sv
module mcyc_mode_reg
    import mcyc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  last,
    input  logic  xfer_req,
    input  logic  xfer_wr,
    output mode_t mode
);
    mode_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (rst) begin
            m_d = '0;
        end else if (last) begin
            // only a normal cycle can open a transfer
            m_d.dcyc = !m_q.dcyc && xfer_req;
            m_d.dwr  = xfer_wr;
        end
    end

    always_ff @(posedge clk) begin
        m_q <= m_d;
    end

    assign mode = m_q;

    // R6: a data cycle is never followed by another data cycle
    a_r6_single_dcyc: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && m_q.dcyc && last) |-> !m_q.dcyc);

    // R9: outside the sampling slot the mode never changes
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !last) |-> $stable(m_q));
endmodule

// File: rtl/mcyc_strobe_dec.sv
module mcyc_strobe_dec
    import mcyc_pkg::*;
#(
    parameter int PSTRB_LEN     = 3,
    parameter int FETCH_B_STATE = 4
) (
    input  logic  rst,
    input  tick_t tick,
    input  mode_t mode,
    input  logic  more_bytes,
    input  logic  xfer_req,
    output logic  fetch_a,
    output logic  fetch_b,
    output logic  op_latch,
    output logic  pc_inc,
    output logic  exec_done,
    output logic  prog_rd_n,
    output logic  data_rd_n,
    output logic  data_wr_n
);
    localparam int SLOT_A    = 0;
    localparam int SLOT_B    = (FETCH_B_STATE - 1) * CLK_PER_STATE;
    localparam int DSTRB_LEN = 2 * PSTRB_LEN;
    localparam int LAST_TICK = CYC_TICKS - 1;
    localparam int NSLOTS    = 2;

    int t_i;
    logic [NSLOTS-1:0] pwin;
    logic dwin;

    assign t_i = int'(tick);

    // one program strobe window per fetch slot, starting in its second phase
    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        localparam int S = (g == 0) ? SLOT_A : SLOT_B;
        assign pwin[g] = (t_i > S) && (t_i <= S + PSTRB_LEN);
    end

    assign dwin = (t_i >= 1) && (t_i <= DSTRB_LEN);

    always_comb begin
        fetch_a   = 1'b0;
        fetch_b   = 1'b0;
        op_latch  = 1'b0;
        pc_inc    = 1'b0;
        exec_done = 1'b0;
        prog_rd_n = 1'b1;
        data_rd_n = 1'b1;
        data_wr_n = 1'b1;
        if (!rst) begin
            if (!mode.dcyc) begin
                fetch_a   = (t_i == SLOT_A);
                fetch_b   = (t_i == SLOT_B);
                op_latch  = (t_i == SLOT_A + 1);
                pc_inc    = (t_i == SLOT_A) || ((t_i == SLOT_B) && more_bytes);
                prog_rd_n = !(|pwin);
                exec_done = (t_i == LAST_TICK) && !xfer_req;
            end else begin
                data_rd_n = !(dwin && !mode.dwr);
                data_wr_n = !(dwin && mode.dwr);
                exec_done = (t_i == LAST_TICK);
            end
        end
    end
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
    import mcyc_pkg::*;
#(
    parameter int PSTRB_LEN     = 3,
    parameter int FETCH_B_STATE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       more_bytes,
    input  logic       xfer_req,
    input  logic       xfer_wr,
    output logic [2:0] state_num,
    output logic       ph1,
    output logic       ph2,
    output logic       fetch_a,
    output logic       fetch_b,
    output logic       op_latch,
    output logic       pc_inc,
    output logic       exec_done,
    output logic       prog_rd_n,
    output logic       data_rd_n,
    output logic       data_wr_n
);
    tick_t tick;
    logic  last;
    mode_t mode;
    logic [STATE_W-1:0] st;

    mcyc_tick_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .state_num (st),
        .ph1       (ph1),
        .ph2       (ph2),
        .last      (last)
    );

    mcyc_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .last     (last),
        .xfer_req (xfer_req),
        .xfer_wr  (xfer_wr),
        .mode     (mode)
    );

    mcyc_strobe_dec #(
        .PSTRB_LEN     (PSTRB_LEN),
        .FETCH_B_STATE (FETCH_B_STATE)
    ) u_dec (
        .rst        (rst),
        .tick       (tick),
        .mode       (mode),
        .more_bytes (more_bytes),
        .xfer_req   (xfer_req),
        .fetch_a    (fetch_a),
        .fetch_b    (fetch_b),
        .op_latch   (op_latch),
        .pc_inc     (pc_inc),
        .exec_done  (exec_done),
        .prog_rd_n  (prog_rd_n),
        .data_rd_n  (data_rd_n),
        .data_wr_n  (data_wr_n)
    );

    assign state_num = 3'(st);

    // R2: nothing is strobed while reset is held
    a_r2_reset_quiet: assert property (@(posedge clk)
        rst |-> prog_rd_n && data_rd_n && data_wr_n && !fetch_a && !fetch_b
                && !op_latch && !pc_inc && !exec_done);

    // R3: the fetch pulses land in the first phase of their states
    a_r3_fetch_a_slot: assert property (@(posedge clk) disable iff (rst)
        fetch_a |-> state_num == 3'd1 && ph1);
    a_r3_fetch_b_slot: assert property (@(posedge clk) disable iff (rst)
        fetch_b |-> state_num == 3'(FETCH_B_STATE) && ph1);

    // R6: the bus carries no program traffic during a data cycle
    a_r6_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        mode.dcyc |-> prog_rd_n && !fetch_a && !fetch_b && !pc_inc && !op_latch);

    // R7: one strobe at a time on the shared bus
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!data_rd_n && !data_wr_n) && !(!prog_rd_n && !(data_rd_n && data_wr_n)));

    // R7: a data strobe opens in S1 Phase 2
    a_r7_data_open: assert property (@(posedge clk) disable iff (rst)
        $fell(data_rd_n && data_wr_n) |-> state_num == 3'd1 && ph2);

    // R8: execution ends only in the final slot
    a_r8_done_last: assert property (@(posedge clk) disable iff (rst)
        exec_done |-> state_num == 3'd6 && ph2);
endmodule

// File: tb/mcyc_sequencer_test.sv
`timescale 1ns/1ps
module mcyc_sequencer_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, more_bytes = 1'b0, xfer_req = 1'b0, xfer_wr = 1'b0;
    logic [2:0] state_num;
    logic ph1, ph2, fetch_a, fetch_b, op_latch, pc_inc, exec_done;
    logic prog_rd_n, data_rd_n, data_wr_n;

    mcyc_sequencer uut (
        .clk(clk), .rst(rst), .more_bytes(more_bytes), .xfer_req(xfer_req),
        .xfer_wr(xfer_wr), .state_num(state_num), .ph1(ph1), .ph2(ph2),
        .fetch_a(fetch_a), .fetch_b(fetch_b), .op_latch(op_latch),
        .pc_inc(pc_inc), .exec_done(exec_done), .prog_rd_n(prog_rd_n),
        .data_rd_n(data_rd_n), .data_wr_n(data_wr_n)
    );

    int total = 0;
    int bad = 0;
    int t_m = 0;
    bit dc_m = 1'b0;
    bit dw_m = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    // one clock: drive, check the current slot, then advance the model
    task automatic step(input bit r, input bit mb, input bit rq, input bit wr);
        bit noisy;
        rst = r; more_bytes = mb; xfer_req = rq; xfer_wr = wr;
        #1;
        noisy = rq && !(t_m == 11 && !dc_m);
        if (r) begin
            if (t_m == 0) begin
                chk("R2", "state_num", int'(state_num), 1);
                chk("R2", "ph1", int'(ph1), 1);
            end
            chk("R2", "fetch_a", int'(fetch_a), 0);
            chk("R2", "fetch_b", int'(fetch_b), 0);
            chk("R2", "op_latch", int'(op_latch), 0);
            chk("R2", "pc_inc", int'(pc_inc), 0);
            chk("R2", "exec_done", int'(exec_done), 0);
            chk("R2", "prog_rd_n", int'(prog_rd_n), 1);
            chk("R2", "data_rd_n", int'(data_rd_n), 1);
            chk("R2", "data_wr_n", int'(data_wr_n), 1);
        end else begin
            chk("R1", "state_num", int'(state_num), t_m / 2 + 1);
            chk("R1", "ph1", int'(ph1), int'(t_m % 2 == 0));
            chk("R1", "ph2", int'(ph2), int'(t_m % 2 == 1));
            if (!dc_m) begin
                chk("R3", "fetch_a", int'(fetch_a), int'(t_m == 0));
                chk("R3", "op_latch", int'(op_latch), int'(t_m == 1));
                chk("R3", "fetch_b", int'(fetch_b), int'(t_m == 6));
                chk("R4", "pc_inc", int'(pc_inc), int'(t_m == 0 || (t_m == 6 && mb)));
                chk(noisy ? "R9" : "R5", "prog_rd_n", int'(prog_rd_n),
                    int'(!((t_m >= 1 && t_m <= 3) || (t_m >= 7 && t_m <= 9))));
                chk("R7", "data_rd_n", int'(data_rd_n), 1);
                chk("R7", "data_wr_n", int'(data_wr_n), 1);
                chk("R8", "exec_done", int'(exec_done), int'(t_m == 11 && !rq));
            end else begin
                chk("R6", "fetch_a", int'(fetch_a), 0);
                chk("R6", "fetch_b", int'(fetch_b), 0);
                chk("R6", "op_latch", int'(op_latch), 0);
                chk("R6", "pc_inc", int'(pc_inc), 0);
                chk(noisy ? "R9" : "R6", "prog_rd_n", int'(prog_rd_n), 1);
                chk("R7", "data_rd_n", int'(data_rd_n), int'(!(t_m >= 1 && t_m <= 6 && !dw_m)));
                chk("R7", "data_wr_n", int'(data_wr_n), int'(!(t_m >= 1 && t_m <= 6 && dw_m)));
                chk("R8", "exec_done", int'(exec_done), int'(t_m == 11));
            end
        end
        @(posedge clk);
        if (r) begin
            t_m = 0; dc_m = 1'b0; dw_m = 1'b0;
        end else if (t_m == 11) begin
            dw_m = wr;
            dc_m = !dc_m && rq;
            t_m = 0;
        end else begin
            t_m++;
        end
        @(negedge clk);
    endtask

    // pattern for one clock of a given cycle; noise on xfer_req off the sampling slot
    task automatic run_cycles(input int first, input int count);
        for (int c = first; c < first + count; c++) begin
            for (int k = 0; k < 12; k++) begin
                bit rq;
                bit mb;
                bit wr;
                if (t_m == 11) rq = ((c * 7) % 5) < 3;
                else           rq = ((c + t_m) % 3) == 0;
                mb = (t_m == 6) ? bit'(c % 2) : bit'((c / 2) % 2);
                wr = bit'(((c / 2) + (c / 4)) % 2);
                step(1'b0, mb, rq, wr);
            end
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        @(negedge clk);
        // R2: reset held with busy inputs
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, bit'(k % 2));
        run_cycles(0, 64);
        // R2: reset arriving in the middle of a cycle
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        run_cycles(64, 24);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule